// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Vector Controller

This block holds the interrupt state shared by the two channels (A and B) of a two-channel serial controller. Each channel keeps a receive-pending bit, a transmit-pending bit, one in-service flag for each, a sticky break flag and a transmit status flag. From these the block builds one interrupt line, a pending-status byte and an interrupt vector byte. The controller's data path, baud logic and register pointer decoder sit outside. They deliver one-cycle event strobes to this block: byte received, data register read, transmit data written, command written, break detected. They also supply the per-channel enable bytes and a global vector-encoding select.

Receive service takes precedence over transmit service. While a channel's receive is in service, a transmit event on that channel only records that transmit is pending. The transmit moves into service once the receive service ends, either through a data read or through the reset-highest-in-service command. Each change of service rewrites the vector with a code chosen by channel, cause and encoding. A host read port returns the vector or the status byte, selected by a 4-bit index.

Top module: `sio_irq_vector_ctrl`

## Requirements
- R1: After reset, irq is 0, the vector reads 0x00, the status byte reads 0x00, and every pending, in-service and break flag is clear.
- R2: irq is 1 exactly when some channel has any of these: transmit pending with enable bit 1 set; receive pending with enable bits 4:3 equal to 01 or 10; break flagged with external-enable bit 7 set. Receive modes 00 and 11 never request.
- R3: A received byte sets that channel's receive-pending and receive-in-service, and writes the channel's receive code into the vector.
- R4: A data read on a channel clears its receive-pending and receive-in-service and writes the no-interrupt code into the vector. If transmit is then pending, it is raised into service as in R5.
- R5: Written transmit data sets transmit-pending. If receive is not in service, transmit enters service and the transmit code is written into the vector. The status transmit bit is set only if enable bit 1 is 1 at that moment.
- R6: A command with bits 5:3 = 111 clears receive-in-service if set, raising a pending transmit per R5. Otherwise it clears transmit-in-service. It leaves the vector unchanged unless a transmit is raised.
- R7: A command with bits 5:3 = 101 clears transmit pending, transmit-in-service and the status transmit bit. It writes the no-interrupt code, then re-raises a still-pending receive per R3. All other command codes have no effect.
- R8: Vector codes (low / high encoding) are: none 0x06/0x60, receive A 0x0C/0x30, receive B 0x04/0x20, transmit A 0x08/0x10, transmit B 0x00/0x00. status_hi selects high encoding when the vector is written, and a later change does not rewrite it.
- R9: Status byte bits: 0 break B (flag and enable), 1 transmit B, 2 receive-pending B, 3 break A (flag and enable), 4 transmit A, 5 receive-pending A, 7:6 zero.
- R10: A detected break sets a channel flag that stays set until reset. Its status bit and request follow the break enable.
- R11: Within one cycle, channel B's events are applied before channel A's, so A's vector write wins. Within a channel the order is received byte, data read, transmit write, command.
- R12: The read port returns the vector at index 2, the status byte at index 3 and 0x00 at every other index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| status_hi | input | 1 | 1 selects the high vector encoding |
| intr_en | input | 2x8 | Per-channel enable byte (index 0 = A): bit 1 transmit enable, bits 4:3 receive mode |
| ext_en | input | 2x8 | Per-channel external enable byte: bit 7 break enable |
| rx_byte | input | 2 | Byte received strobe per channel |
| data_rd | input | 2 | Data register read strobe per channel |
| tx_wr | input | 2 | Transmit data written strobe per channel |
| cmd_wr | input | 2 | Command write strobe per channel |
| cmd_code | input | 2x8 | Command byte per channel, bits 5:3 decoded |
| brk_det | input | 2 | Break detected strobe per channel |
| rd_idx | input | 4 | Host read register index |
| rd_data | output | 8 | Host read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench goes after the transmit-behind-receive ordering. It writes transmit data while a receive is in service and checks that the vector keeps the receive code until a read or a reset-highest command releases the transmit. A design that promoted transmit at once would show 0x08 or 0x00 too early. A design that never promoted it would keep the no-interrupt code. The bench also drives the clear-transmit command while a receive is pending but not in service. A design that forgot to re-raise the receive would leave the vector at 0x06. Further cases cover receive modes 00 and 11, which must set status without requesting. They also cover a transmit written while disabled, which must request later without a status bit, the sticky break under a changing enable, and simultaneous events. Here a wrong order would leave channel B's code or a stale receive-pending bit in place.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

    localparam int NCH  = 2;
    localparam int CH_A = 0;
    localparam int CH_B = 1;
    localparam int BW   = 8;

    typedef enum logic [1:0] {
        CAUSE_NONE = 2'd0,
        CAUSE_RX   = 2'd1,
        CAUSE_TX   = 2'd2
    } cause_e;

    typedef struct packed {
        logic brk;
        logic tx_flag;
        logic tx_svc;
        logic tx_pend;
        logic rx_svc;
        logic rx_pend;
    } chan_st_t;

    typedef struct packed {
        chan_st_t [NCH-1:0] ch;
        logic [BW-1:0]      vec;
    } ctl_st_t;

    // Low codes are fixed; the high code moves low bits 3,2,1 to bits 4,5,6.
    function automatic logic [BW-1:0] vec_code(input logic hi, input logic is_b,
                                               input cause_e cause);
        logic [BW-1:0] lo;
        case (cause)
            CAUSE_RX: lo = is_b ? 8'h04 : 8'h0C;
            CAUSE_TX: lo = is_b ? 8'h00 : 8'h08;
            default:  lo = 8'h06;
        endcase
        if (hi) return {1'b0, lo[1], lo[2], lo[3], 4'h0};
        return lo;
    endfunction

endpackage

// File: rtl/sio_irq_req.sv
module sio_irq_req
    import sio_irq_pkg::*;
(
    input  chan_st_t      st,
    input  logic [BW-1:0] intr_en,
    input  logic [BW-1:0] ext_en,
    output logic          req,
    output logic          ext_bit
);
    logic [1:0] rx_mode;
    logic       rx_on;

    always_comb begin
        rx_mode = intr_en[4:3];
        rx_on   = (rx_mode == 2'b01) || (rx_mode == 2'b10);
        ext_bit = st.brk & ext_en[7];
        req     = (st.tx_pend & intr_en[1]) | (st.rx_pend & rx_on) | ext_bit;
    end
endmodule

// File: rtl/sio_irq_rdmux.sv
module sio_irq_rdmux
    import sio_irq_pkg::*;
#(
    parameter int IDXW     = 4,
    parameter int VEC_IDX  = 2,
    parameter int STAT_IDX = 3
) (
    input  logic [IDXW-1:0] idx,
    input  logic [BW-1:0]   vec,
    input  logic [BW-1:0]   stat,
    output logic [BW-1:0]   rd_data
);
    always_comb begin
        if (idx == IDXW'(VEC_IDX))       rd_data = vec;
        else if (idx == IDXW'(STAT_IDX)) rd_data = stat;
        else                             rd_data = '0;
    end
endmodule

// File: rtl/sio_irq_vector_ctrl.sv
module sio_irq_vector_ctrl
    import sio_irq_pkg::*;
#(
    parameter int IDXW     = 4,
    parameter int VEC_IDX  = 2,
    parameter int STAT_IDX = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   status_hi,
    input  logic [NCH-1:0][BW-1:0] intr_en,
    input  logic [NCH-1:0][BW-1:0] ext_en,
    input  logic [NCH-1:0]         rx_byte,
    input  logic [NCH-1:0]         data_rd,
    input  logic [NCH-1:0]         tx_wr,
    input  logic [NCH-1:0]         cmd_wr,
    input  logic [NCH-1:0][BW-1:0] cmd_code,
    input  logic [NCH-1:0]         brk_det,
    input  logic [IDXW-1:0]        rd_idx,
    output logic [BW-1:0]          rd_data,
    output logic                   irq
);
    localparam logic [2:0] CMD_RST_SVC = 3'b111;
    localparam logic [2:0] CMD_CLR_TX  = 3'b101;

    ctl_st_t        st_q, st_d;
    logic [NCH-1:0] req;
    logic [BW-1:0]  stat;

    function automatic ctl_st_t raise_rx(input ctl_st_t s, input int c, input logic hi);
        s.ch[c].rx_pend = 1'b1;
        s.ch[c].rx_svc  = 1'b1;
        s.vec           = vec_code(hi, c == CH_B, CAUSE_RX);
        return s;
    endfunction

    function automatic ctl_st_t raise_tx(input ctl_st_t s, input int c,
                                         input logic en, input logic hi);
        s.ch[c].tx_pend = 1'b1;
        if (!s.ch[c].rx_svc) begin
            s.ch[c].tx_svc = 1'b1;
            if (en) s.ch[c].tx_flag = 1'b1;
            s.vec = vec_code(hi, c == CH_B, CAUSE_TX);
        end
        return s;
    endfunction

    // Channel B first, then A, so channel A's vector write lands last.
    always_comb begin
        st_d = st_q;
        for (int c = NCH - 1; c >= 0; c--) begin
            if (brk_det[c]) st_d.ch[c].brk = 1'b1;
            if (rx_byte[c]) st_d = raise_rx(st_d, c, status_hi);
            if (data_rd[c]) begin
                st_d.ch[c].rx_pend = 1'b0;
                st_d.ch[c].rx_svc  = 1'b0;
                st_d.vec           = vec_code(status_hi, c == CH_B, CAUSE_NONE);
                if (st_d.ch[c].tx_pend) st_d = raise_tx(st_d, c, intr_en[c][1], status_hi);
            end
            if (tx_wr[c]) st_d = raise_tx(st_d, c, intr_en[c][1], status_hi);
            if (cmd_wr[c]) begin
                case (cmd_code[c][5:3])
                    CMD_RST_SVC: begin
                        if (st_d.ch[c].rx_svc) begin
                            st_d.ch[c].rx_svc = 1'b0;
                            if (st_d.ch[c].tx_pend)
                                st_d = raise_tx(st_d, c, intr_en[c][1], status_hi);
                        end else begin
                            st_d.ch[c].tx_svc = 1'b0;
                        end
                    end
                    CMD_CLR_TX: begin
                        st_d.ch[c].tx_pend = 1'b0;
                        st_d.ch[c].tx_svc  = 1'b0;
                        st_d.ch[c].tx_flag = 1'b0;
                        st_d.vec = vec_code(status_hi, c == CH_B, CAUSE_NONE);
                        if (st_d.ch[c].rx_pend) st_d = raise_rx(st_d, c, status_hi);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat[7:6] = 2'b00;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        localparam int BASE = (c == CH_B) ? 0 : 3;
        logic ext_bit;

        sio_irq_req u_req (
            .st      (st_q.ch[c]),
            .intr_en (intr_en[c]),
            .ext_en  (ext_en[c]),
            .req     (req[c]),
            .ext_bit (ext_bit)
        );

        assign stat[BASE]     = ext_bit;
        assign stat[BASE + 1] = st_q.ch[c].tx_flag;
        assign stat[BASE + 2] = st_q.ch[c].rx_pend;

        // R3
        rx_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rx_byte[c] && !data_rd[c] |=> st_q.ch[c].rx_pend);
        // R4
        rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            data_rd[c] |=> !st_q.ch[c].rx_pend && !st_q.ch[c].rx_svc);
        // R5
        tx_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tx_wr[c] && st_q.ch[c].rx_svc && !st_q.ch[c].tx_svc && !data_rd[c] && !cmd_wr[c]
            |=> !st_q.ch[c].tx_svc);
        // R6
        svc_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ch[c].tx_svc |-> st_q.ch[c].tx_pend);
        // R7
        clr_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cmd_wr[c] && cmd_code[c][5:3] == CMD_CLR_TX
            |=> !st_q.ch[c].tx_pend && !st_q.ch[c].tx_flag);
        // R10
        brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.ch[c].brk |=> st_q.ch[c].brk);
    end

    assign irq = |req;

    sio_irq_rdmux #(
        .IDXW     (IDXW),
        .VEC_IDX  (VEC_IDX),
        .STAT_IDX (STAT_IDX)
    ) u_rdmux (
        .idx     (rd_idx),
        .vec     (st_q.vec),
        .stat    (stat),
        .rd_data (rd_data)
    );
endmodule

// File: tb/sim_sio_irq_vector_ctrl.sv
module sim_sio_irq_vector_ctrl;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            status_hi = 1'b0;
    logic [1:0][7:0] intr_en = '0;
    logic [1:0][7:0] ext_en = '0;
    logic [1:0]      rx_byte = '0, data_rd = '0, tx_wr = '0, cmd_wr = '0, brk_det = '0;
    logic [1:0][7:0] cmd_code = '0;
    logic [3:0]      rd_idx = '0;
    logic [7:0]      rd_data;
    logic            irq;
    int              n_chk = 0;
    int              n_fail = 0;
    bit              done = 1'b0;

    always #10 clk = ~clk;

    sio_irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .status_hi(status_hi), .intr_en(intr_en),
        .ext_en(ext_en), .rx_byte(rx_byte), .data_rd(data_rd), .tx_wr(tx_wr),
        .cmd_wr(cmd_wr), .cmd_code(cmd_code), .brk_det(brk_det),
        .rd_idx(rd_idx), .rd_data(rd_data), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic look(input string req, input logic exp_irq,
                        input logic [7:0] exp_vec, input logic [7:0] exp_st);
        rd_idx = 4'd2; #1;
        chk({req, " vector"}, rd_data, exp_vec);
        rd_idx = 4'd3; #1;
        chk({req, " status"}, rd_data, exp_st);
        chk({req, " irq"}, {7'b0, irq}, {7'b0, exp_irq});
    endtask

    // bit 0 of each mask = channel A, bit 1 = channel B
    task automatic fire(input logic [1:0] rx, input logic [1:0] rd, input logic [1:0] tx,
                        input logic [1:0] cm, input logic [1:0] bk,
                        input logic [7:0] ca, input logic [7:0] cb);
        rx_byte = rx; data_rd = rd; tx_wr = tx; cmd_wr = cm; brk_det = bk;
        cmd_code[0] = ca; cmd_code[1] = cb;
        @(negedge clk);
        rx_byte = '0; data_rd = '0; tx_wr = '0; cmd_wr = '0; brk_det = '0;
        cmd_code = '0;
    endtask

    task automatic do_reset();
        intr_en = '0; ext_en = '0; status_hi = 1'b0;
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        look("R1", 1'b0, 8'h00, 8'h00);
        rd_idx = 4'd7; #1;
        chk("R12 other index", rd_data, 8'h00);
    endtask

    task automatic t_rx_low();
        do_reset();
        intr_en[0] = 8'h08;
        fire(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R3 rx A low", 1'b1, 8'h0C, 8'h20);
        fire(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R4 read A", 1'b0, 8'h06, 8'h00);
    endtask

    task automatic t_high();
        do_reset();
        status_hi = 1'b1;
        intr_en[1] = 8'h10;
        fire(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R8 rx B high", 1'b1, 8'h20, 8'h04);
        fire(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R8 none high", 1'b0, 8'h60, 8'h00);
        intr_en[0] = 8'h02;
        fire(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R8 tx A high", 1'b1, 8'h10, 8'h10);
        status_hi = 1'b0;
        look("R8 select change keeps vector", 1'b1, 8'h10, 8'h10);
    endtask

    task automatic t_rx_modes();
        do_reset();
        intr_en[0] = 8'h18;
        fire(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R2 mode 11 no request", 1'b0, 8'h0C, 8'h20);
        intr_en[0] = 8'h00;
        look("R2 mode 00 no request", 1'b0, 8'h0C, 8'h20);
        intr_en[0] = 8'h10;
        look("R2 mode 10 requests", 1'b1, 8'h0C, 8'h20);
    endtask

    task automatic t_tx_block();
        do_reset();
        intr_en[0] = 8'h0A;
        fire(2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R3 rx A", 1'b1, 8'h0C, 8'h20);
        fire(2'b00, 2'b00, 2'b01, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R5 tx held behind rx", 1'b1, 8'h0C, 8'h20);
        rd_idx = 4'd5; #1;
        chk("R12 index 5", rd_data, 8'h00);
        fire(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R4 read promotes tx A", 1'b1, 8'h08, 8'h10);
        fire(2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 8'h10, 8'h00);
        look("R7 other command ignored", 1'b1, 8'h08, 8'h10);
        fire(2'b00, 2'b00, 2'b00, 2'b01, 2'b00, 8'h28, 8'h00);
        look("R7 clear tx A", 1'b0, 8'h06, 8'h00);
    endtask

    task automatic t_ius();
        do_reset();
        intr_en[1] = 8'h0A;
        fire(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R3 rx B", 1'b1, 8'h04, 8'h04);
        fire(2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R5 tx B held", 1'b1, 8'h04, 8'h04);
        fire(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 8'h00, 8'h38);
        look("R6 first reset promotes tx B", 1'b1, 8'h00, 8'h06);
        fire(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 8'h00, 8'h38);
        look("R6 second reset keeps vector", 1'b1, 8'h00, 8'h06);
        fire(2'b00, 2'b00, 2'b00, 2'b10, 2'b00, 8'h00, 8'h28);
        look("R7 clear tx re-raises rx B", 1'b1, 8'h04, 8'h04);
        fire(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R4 read B", 1'b0, 8'h06, 8'h00);
    endtask

    task automatic t_break();
        do_reset();
        ext_en[0] = 8'h80;
        fire(2'b00, 2'b00, 2'b00, 2'b00, 2'b01, 8'h00, 8'h00);
        look("R10 break A", 1'b1, 8'h00, 8'h08);
        fire(2'b00, 2'b00, 2'b00, 2'b00, 2'b10, 8'h00, 8'h00);
        look("R10 break B disabled", 1'b1, 8'h00, 8'h08);
        ext_en[1] = 8'h80;
        look("R9 both break bits", 1'b1, 8'h00, 8'h09);
        repeat (3) @(negedge clk);
        look("R10 break sticky", 1'b1, 8'h00, 8'h09);
        ext_en = '0;
        look("R10 enable off", 1'b0, 8'h00, 8'h00);
    endtask

    task automatic t_prio();
        do_reset();
        intr_en[0] = 8'h08; intr_en[1] = 8'h08;
        fire(2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R11 A wins vector", 1'b1, 8'h0C, 8'h24);
        fire(2'b00, 2'b01, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R9 B still pending", 1'b1, 8'h06, 8'h04);
        fire(2'b10, 2'b10, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R11 read after rx same cycle", 1'b0, 8'h06, 8'h00);
    endtask

    task automatic t_tx_noen();
        do_reset();
        fire(2'b10, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R3 rx B mode 00", 1'b0, 8'h04, 8'h04);
        fire(2'b00, 2'b10, 2'b00, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R4 read B", 1'b0, 8'h06, 8'h00);
        fire(2'b00, 2'b00, 2'b10, 2'b00, 2'b00, 8'h00, 8'h00);
        look("R5 tx B disabled", 1'b0, 8'h00, 8'h00);
        intr_en[1] = 8'h02;
        look("R2 tx B enabled later", 1'b1, 8'h00, 8'h00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_rx_low();
        t_high();
        t_rx_modes();
        t_tx_block();
        t_ius();
        t_break();
        t_prio();
        t_tx_noen();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule